// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block owns the internal chip reset. It starts a reset sequence on any of three events: a power-on request, a supply-low flag from an analog comparator, or a wake request from sleep. Each sequence runs through a fixed chain of hold stages before it lets the chip run. An optional power-up delay is counted in pulses of a slow RC time base. An oscillator settling stage then counts main-clock cycles, but only for crystal or resonator modes and only after a power-on or a wake. A brown-out hold keeps reset asserted for as long as the supply stays low.

The supply-low flag and the power-on request are asynchronous and pass through a synchroniser before use. A supply dip must last a minimum number of clock samples before it counts as a brown-out. The exception is a dip that arrives while the power-up delay is counting: that one sends the block back to brown-out hold at once, and the delay restarts from zero. A two-bit cause code records which event started the current or last sequence.

All delays are parameters: `PWRT_TICKS` RC ticks, `OST_CYC` clock cycles and `BO_QUAL_CYC` clock samples. Asserting `arst_n` low acts like a power-on.

Top module: `rsq_ctrl`

## Requirements
- R1: While `arst_n` is low and just after it goes high, `chip_rst` is 1 and `rst_cause` is 2'b01 (power-on). `rst_cause` never reads 2'b00.
- R2: After the synchronised `por_req` goes low with `pwrup_en`=1, reset stays asserted until `PWRT_TICKS` cycles with `rc_tick` high have been seen. When no oscillator stage follows, `chip_rst` is 0 right after the clock edge that samples the last tick.
- R3: On power-on with `pwrup_en`=0, the delay stage is skipped, and no `rc_tick` is needed to release reset.
- R4: `osc_mode` values 2'b00, 2'b01 and 2'b10 are crystal modes. After a power-on delay in a crystal mode, `chip_rst` stays 1 for exactly `OST_CYC` further clock cycles. With `osc_mode`=2'b11 the oscillator stage never runs.
- R5: A one-cycle `wake_req` while the chip is running, in a crystal mode, holds `chip_rst` high for exactly `OST_CYC` cycles and sets `rst_cause` to 2'b11. With `osc_mode`=2'b11 it has no effect on `chip_rst` or `rst_cause`.
- R6: With `brown_en`=1, a `low_supply` level sampled high on `BO_QUAL_CYC` consecutive clocks starts a brown-out reset with `rst_cause`=2'b10. A dip of `BO_QUAL_CYC`-1 samples has no effect.
- R7: With `brown_en`=0, `low_supply` has no effect on `chip_rst` or `rst_cause`.
- R8: During a brown-out, reset holds while `low_supply` is high. After it clears, the full power-up delay always runs, even with `pwrup_en`=0, and no oscillator stage follows.
- R9: When `low_supply` is high during the power-up delay and `brown_en`=1, the block returns to brown-out hold with no qualification time, and the delay count restarts from zero.
- R10: `por_req` overrides every stage: it re-asserts `chip_rst`, sets `rst_cause` to 2'b01 and restarts the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| arst_n | input | 1 | Asynchronous active-low reset, treated as power-on |
| rc_tick | input | 1 | One-cycle pulse from the slow RC time base |
| por_req | input | 1 | Asynchronous power-on request, active high |
| low_supply | input | 1 | Asynchronous supply-below-threshold flag |
| pwrup_en | input | 1 | Enables the power-up delay after power-on |
| brown_en | input | 1 | Enables brown-out detection |
| osc_mode | input | 2 | Oscillator mode; 2'b11 is the non-crystal mode |
| wake_req | input | 1 | Synchronous wake-from-sleep request |
| chip_rst | output | 1 | Internal chip reset, active high |
| rst_cause | output | 2 | 01 power-on, 10 brown-out, 11 wake |

## Verification
The bench measures the oscillator hold exactly, in cycles. A counter off by one would shorten or lengthen the reset by a cycle. A design that ran the oscillator stage after a brown-out would add `OST_CYC` cycles.

It sends a dip one sample short of qualification, which a loose comparator would wrongly turn into a reset. It also sends a short dip during the power-up delay and then supplies fewer ticks than a full delay after the dip. A design that resumed the delay instead of restarting it would release reset early.

Wake requests in the non-crystal mode and long dips with brown-out disabled must leave both outputs unchanged.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      S_HOLD = 3'd0,
      S_PWRT = 3'd1,
      S_OST  = 3'd2,
      S_BOR  = 3'd3,
      S_RUN  = 3'd4
   } rsq_state_e;

   typedef enum logic [1:0] {
      C_NONE = 2'b00,
      C_POR  = 2'b01,
      C_BOR  = 2'b10,
      C_WAKE = 2'b11
   } rsq_cause_e;

   localparam logic [1:0] OSC_NON_XTAL = 2'b11;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rsq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) pipe[i] <= '0;
            else         pipe[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n)
            if (!arst_n) pipe[i] <= '0;
            else         pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/rsq_cnt.sv
module rsq_cnt #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic arst_n,
   input  logic clr,
   input  logic en,
   output logic last
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("rsq_cnt: LIMIT must be at least 1");
   end

   localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] TOP = W'(LIMIT - 1);

   logic [W-1:0] cnt_q;

   assign last = en && (cnt_q == TOP);

   always_ff @(posedge clk or negedge arst_n)
      if (!arst_n)    cnt_q <= '0;
      else if (clr)   cnt_q <= '0;
      else if (last)  cnt_q <= '0;
      else if (en)    cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
   import rsq_pkg::*;
#(
   parameter int unsigned PWRT_TICKS  = 72,
   parameter int unsigned OST_CYC     = 1024,
   parameter int unsigned BO_QUAL_CYC = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       rc_tick,
   input  logic       por_req,
   input  logic       low_supply,
   input  logic       pwrup_en,
   input  logic       brown_en,
   input  logic [1:0] osc_mode,
   input  logic       wake_req,
   output logic       chip_rst,
   output logic [1:0] rst_cause
);
   if (PWRT_TICKS < 1 || OST_CYC < 1 || BO_QUAL_CYC < 1) begin : g_bad_delays
      $error("rsq_ctrl: every delay must be at least one unit");
   end

   rsq_state_e st_q, st_d;
   rsq_cause_e cause_q, cause_d;

   logic por_s, low_s;
   logic [1:0] sync_q;

   rsq_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      ({por_req, low_supply}),
      .q      (sync_q)
   );
   assign por_s = sync_q[1];
   assign low_s = sync_q[0];

   logic xtal;
   assign xtal = (osc_mode != OSC_NON_XTAL);

   logic pw_last, os_last, bo_last, bo_en, bo_trip;

   rsq_cnt #(.LIMIT(PWRT_TICKS)) u_pwrt_cnt (
      .clk (clk), .arst_n (arst_n),
      .clr (st_q != S_PWRT), .en (rc_tick), .last (pw_last)
   );

   rsq_cnt #(.LIMIT(OST_CYC)) u_ost_cnt (
      .clk (clk), .arst_n (arst_n),
      .clr (st_q != S_OST), .en (1'b1), .last (os_last)
   );

   assign bo_en = low_s && brown_en;

   rsq_cnt #(.LIMIT(BO_QUAL_CYC)) u_bo_cnt (
      .clk (clk), .arst_n (arst_n),
      .clr (!bo_en), .en (bo_en), .last (bo_last)
   );

   assign bo_trip = bo_last && ((st_q == S_OST) || (st_q == S_RUN));

   always_comb begin
      st_d    = st_q;
      cause_d = cause_q;
      unique case (st_q)
         S_HOLD: st_d = pwrup_en ? S_PWRT : (xtal ? S_OST : S_RUN);
         S_PWRT: begin
            if (brown_en && low_s) begin
               st_d    = S_BOR;
               cause_d = C_BOR;
            end else if (pw_last) begin
               st_d = (xtal && cause_q != C_BOR) ? S_OST : S_RUN;
            end
         end
         S_OST:  if (os_last) st_d = S_RUN;
         S_BOR:  if (!low_s) st_d = S_PWRT;
         S_RUN: begin
            if (wake_req && xtal) begin
               st_d    = S_OST;
               cause_d = C_WAKE;
            end
         end
         default: st_d = S_HOLD;
      endcase
      if (bo_trip) begin
         st_d    = S_BOR;
         cause_d = C_BOR;
      end
      if (por_s) begin
         st_d    = S_HOLD;
         cause_d = C_POR;
      end
   end

   always_ff @(posedge clk or negedge arst_n)
      if (!arst_n) begin
         st_q    <= S_HOLD;
         cause_q <= C_POR;
      end else begin
         st_q    <= st_d;
         cause_q <= cause_d;
      end

   assign chip_rst  = (st_q != S_RUN);
   assign rst_cause = cause_q;
endmodule

// File: rtl/rsq_ctrl_chk.sv
module rsq_ctrl_chk
   import rsq_pkg::*;
(
   input logic       clk,
   input logic       arst_n,
   input rsq_state_e st_q,
   input rsq_cause_e cause_q,
   input logic       por_s,
   input logic       low_s,
   input logic       bo_trip,
   input logic       brown_en,
   input logic [1:0] osc_mode,
   input logic       wake_req,
   input logic       chip_rst
);
   p_cause_valid_r1: assert property (@(posedge clk) disable iff (!arst_n)
      cause_q != C_NONE);

   p_release_r2: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(chip_rst) |-> ($past(st_q) == S_PWRT || $past(st_q) == S_OST
                           || $past(st_q) == S_HOLD));

   p_no_ost_rc_r4: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q != S_OST && osc_mode == OSC_NON_XTAL) |=> st_q != S_OST);

   p_wake_r5: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == S_RUN && wake_req && osc_mode != OSC_NON_XTAL && !por_s && !bo_trip)
      |=> (st_q == S_OST && cause_q == C_WAKE));

   p_bo_off_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (!brown_en && st_q == S_RUN && !por_s && !wake_req) |=> st_q == S_RUN);

   p_bor_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == S_BOR && low_s && !por_s) |=> (st_q == S_BOR && chip_rst));

   p_pwrt_drop_r9: assert property (@(posedge clk) disable iff (!arst_n)
      (st_q == S_PWRT && low_s && brown_en && !por_s) |=> st_q == S_BOR);

   p_por_r10: assert property (@(posedge clk) disable iff (!arst_n)
      por_s |=> (st_q == S_HOLD && cause_q == C_POR));
endmodule

bind rsq_ctrl rsq_ctrl_chk u_chk (
   .clk      (clk),
   .arst_n   (arst_n),
   .st_q     (st_q),
   .cause_q  (cause_q),
   .por_s    (por_s),
   .low_s    (low_s),
   .bo_trip  (bo_trip),
   .brown_en (brown_en),
   .osc_mode (osc_mode),
   .wake_req (wake_req),
   .chip_rst (chip_rst)
);

// File: tb/sim_rsq_ctrl.sv
`timescale 1ns/1ps
module sim_rsq_ctrl;
   localparam int PW  = 5;
   localparam int OST = 8;
   localparam int BOQ = 6;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic rc_tick = 1'b0, por_req = 1'b0, low_supply = 1'b0;
   logic pwrup_en = 1'b1, brown_en = 1'b1, wake_req = 1'b0;
   logic [1:0] osc_mode = 2'b11;
   logic chip_rst;
   logic [1:0] rst_cause;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rsq_ctrl #(.PWRT_TICKS(PW), .OST_CYC(OST), .BO_QUAL_CYC(BOQ)) u0 (
      .clk, .arst_n, .rc_tick, .por_req, .low_supply, .pwrup_en,
      .brown_en, .osc_mode, .wake_req, .chip_rst, .rst_cause
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         rc_tick = 1'b1; @(negedge clk);
         rc_tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic count_rst(output int n);
      n = 0;
      while (chip_rst && n < 200) begin n++; @(negedge clk); end
   endtask

   task automatic por_pulse();
      por_req = 1'b1; idle(3); por_req = 1'b0; idle(6);
   endtask

   task automatic t_reset_r1();
      chk("R1 rst during reset", chip_rst, 1);
      chk("R1 cause during reset", rst_cause, 1);
      arst_n = 1'b1; idle(2);
      chk("R1 rst after reset", chip_rst, 1);
      chk("R1 cause after reset", rst_cause, 1);
   endtask

   task automatic t_pwrt_r2();
      ticks(PW - 1);
      chk("R2 held before last tick", chip_rst, 1);
      ticks(1);
      chk("R2 released after last tick", chip_rst, 0);
   endtask

   task automatic t_ost_r4();
      int n;
      osc_mode = 2'b01; por_pulse();
      chk("R10 cause after por", rst_cause, 1);
      ticks(PW - 1);
      rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
      count_rst(n);
      chk("R4 oscillator hold length", n, OST);
   endtask

   task automatic t_wake_r5();
      int n;
      osc_mode = 2'b10;
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      chk("R5 cause wake", rst_cause, 3);
      count_rst(n);
      chk("R5 wake hold length", n, OST);
      osc_mode = 2'b11;
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      idle(10);
      chk("R5 rc wake no reset", chip_rst, 0);
      chk("R5 rc wake cause kept", rst_cause, 3);
   endtask

   task automatic t_nodelay_r3();
      pwrup_en = 1'b0; osc_mode = 2'b11; por_pulse();
      idle(2);
      chk("R3 released without ticks", chip_rst, 0);
      chk("R3 cause power-on", rst_cause, 1);
   endtask

   task automatic t_dip_r6_r7();
      brown_en = 1'b1;
      low_supply = 1'b1; idle(BOQ - 1); low_supply = 1'b0; idle(10);
      chk("R6 short dip ignored", chip_rst, 0);
      chk("R6 short dip cause kept", rst_cause, 1);
      brown_en = 1'b0;
      low_supply = 1'b1; idle(3 * BOQ); low_supply = 1'b0; idle(10);
      chk("R7 disabled brown-out rst", chip_rst, 0);
      chk("R7 disabled brown-out cause", rst_cause, 1);
      brown_en = 1'b1;
   endtask

   task automatic t_bor_r8();
      pwrup_en = 1'b0; osc_mode = 2'b00;
      low_supply = 1'b1; idle(BOQ + 4);
      chk("R6 long dip trips", chip_rst, 1);
      chk("R6 cause brown-out", rst_cause, 2);
      idle(20);
      chk("R8 held while low", chip_rst, 1);
      low_supply = 1'b0; idle(6);
      chk("R8 delay runs after release", chip_rst, 1);
      ticks(PW - 1);
      chk("R8 held before last tick", chip_rst, 1);
      ticks(1);
      chk("R8 no oscillator stage after brown-out", chip_rst, 0);
   endtask

   task automatic t_restart_r9();
      low_supply = 1'b1; idle(BOQ + 4); low_supply = 1'b0; idle(6);
      ticks(3);
      low_supply = 1'b1; idle(2); low_supply = 1'b0; idle(8);
      chk("R9 back in reset", chip_rst, 1);
      chk("R9 cause brown-out", rst_cause, 2);
      ticks(PW - 1);
      chk("R9 delay restarted", chip_rst, 1);
      ticks(1);
      chk("R9 released after full delay", chip_rst, 0);
   endtask

   task automatic t_por_override_r10();
      pwrup_en = 1'b1; osc_mode = 2'b01;
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      idle(2);
      por_req = 1'b1; idle(3);
      chk("R10 rst under por", chip_rst, 1);
      chk("R10 cause por", rst_cause, 1);
      por_req = 1'b0; idle(6 + OST);
      chk("R10 chain restarted", chip_rst, 1);
      osc_mode = 2'b11;
      ticks(PW);
      chk("R10 released after delay", chip_rst, 0);
   endtask

   initial begin
      idle(3);
      t_reset_r1();
      t_pwrt_r2();
      t_ost_r4();
      t_wake_r5();
      t_nodelay_r3();
      t_dip_r6_r7();
      t_bor_r8();
      t_restart_r9();
      t_por_override_r10();
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule